// File: doc/BRIEF.md
# Cascaded Prioritized Interrupt Controller

This block gathers interrupt lines from peripherals and presents two CPU-facing requests: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). It contains two identical controller units of 32 sources each. The secondary unit's normal and fast requests drive sources 0 and 1 of the primary unit. That leaves 32 secondary lines and 30 primary lines, 62 in all, for peripherals. Only the primary unit's requests leave the block.

Each source has a configuration word that selects its priority (0 is most urgent), its capture mode (level or rising edge) and its route (normal or fast). Each unit also has a mask register, a pending register and two read-only winner registers. A winner register names the most urgent unmasked pending source on its path. A request output is high exactly while its winner is valid. Edge captures stay pending until software acknowledges them by writing a one to the pending bit.

Software reaches all registers through a small request/acknowledge bus. A two-state bus sequencer handles it:
- In `BUS_IDLE` the sequencer accepts a request. Transition *accept*: `BUS_IDLE` → `BUS_REPLY`. A write takes effect at the accepting clock edge, and read data is captured at that same edge.
- In `BUS_REPLY` the sequencer raises the acknowledge for one cycle and then returns. Transition *release*: `BUS_REPLY` → `BUS_IDLE`, unconditionally.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset both mask registers read 0xFFFFFFFF, both pending registers read 0, every configuration word reads 0, and `irq_o` and `fiq_o` are low.
- R2: Address bit 6 selects the unit (0 primary, 1 secondary). When address bit 5 is 1, bits 4:0 pick a source's configuration word. In that word bits 4:0 hold the priority, bit 8 selects edge capture when 1, and bit 9 routes the source to the fast path when 1. All other bits read 0.
- R3: With address bit 5 equal to 0, address bits 1:0 select 0 for the mask, 1 for pending, 2 for the normal winner and 3 for the fast winner. For a level source, the pending bit equals the input as it was one clock earlier.
- R4: For an edge source, a rising input sets its pending bit, which then stays set until a write to the pending register carries a 1 in that bit position. A 0 written to that bit leaves it unchanged.
- R5: A set mask bit keeps its source out of both winner registers and both outputs. The pending bit still records the source.
- R6: A source with route bit 0 can win only the normal path, and a source with route bit 1 can win only the fast path.
- R7: Among the eligible sources of a path, the lowest priority value wins. A tie goes to the lowest source number.
- R8: A winner register reads bit 31 = valid and bits 4:0 = source number, with all other bits 0. The primary unit's `irq_o` and `fiq_o` equal the valid bits of its normal and fast winners.
- R9: Primary source 0 is the secondary normal request, primary source 1 is the secondary fast request, and `pri_src[k]` is primary source k+2.
- R10: Each accepted request gets exactly one acknowledge cycle, one clock after acceptance, with read data valid during that cycle. Writes to the winner registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address (unit, space, register/source) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access acknowledge |
| sec_src | input | 32 | Secondary unit peripheral lines |
| pri_src | input | 30 | Primary unit peripheral lines (sources 2..31) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with its default parameters: 32 sources per unit and 5-bit priorities. These defaults make the full cascade and every priority value reachable. The random phase restricts priorities to 0 to 3 so that many sources tie, which puts the lowest-number tie rule and mixed routing under heavy use. Directed cases cover edge capture and acknowledge, masking, and a request propagating through the cascade inputs.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int PRIO_W      = 5;
    localparam int CFG_EDGE_BIT  = 8;
    localparam int CFG_ROUTE_BIT = 9;

    typedef struct packed {
        logic              route_fiq;
        logic              edge_trig;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

    typedef enum logic [1:0] {
        CTL_MASK    = 2'd0,
        CTL_PEND    = 2'd1,
        CTL_IRQ_WIN = 2'd2,
        CTL_FIQ_WIN = 2'd3
    } ctl_reg_e;

    typedef enum logic {
        BUS_IDLE  = 1'b0,
        BUS_REPLY = 1'b1
    } bus_state_e;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] edge_mode_i,
    input  logic [NSRC-1:0] ack_clr_i,
    output logic [NSRC-1:0] pend_o
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] pend_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                pend_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= src_i[g];
                if (edge_mode_i[g])
                    pend_q[g] <= (src_i[g] & ~prev_q[g]) | (pend_q[g] & ~ack_clr_i[g]);
                else
                    pend_q[g] <= src_i[g];
            end
        end

        // R3: a level source mirrors its input one cycle later
        assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !edge_mode_i[g] |=> (pend_q[g] == $past(src_i[g])));

        // R4: an edge capture survives until acknowledged
        assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_mode_i[g] && pend_q[g] && !ack_clr_i[g]) |=> pend_q[g]);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NSRC   = 32,
    parameter int PRIO_W = 5,
    localparam int ID_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   req_i,
    input  logic [PRIO_W-1:0] prio_i [NSRC],
    output logic              valid_o,
    output logic [ID_W-1:0]   id_o
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        best_p  = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (!valid_o || (prio_i[i] < best_p))) begin
                valid_o = 1'b1;
                id_o    = ID_W'(i);
                best_p  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_unit.sv
module intc_unit
    import intc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int DATA_W = 32,
    localparam int ID_W  = $clog2(NSRC),
    localparam int OFF_W = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    src_cfg_t          cfg_q [NSRC];
    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   edge_mode;
    logic [NSRC-1:0]   route_fiq;
    logic [NSRC-1:0]   ack_clr;
    logic [NSRC-1:0]   elig_irq;
    logic [NSRC-1:0]   elig_fiq;
    logic [PRIO_W-1:0] prio_v [NSRC];
    logic              irq_valid, fiq_valid;
    logic [ID_W-1:0]   irq_id, fiq_id;
    logic              cfg_space;
    logic [ID_W-1:0]   idx;
    ctl_reg_e          ctl_sel;

    assign cfg_space = reg_addr[OFF_W-1];
    assign idx       = reg_addr[ID_W-1:0];
    assign ctl_sel   = ctl_reg_e'(reg_addr[1:0]);

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            edge_mode[i] = cfg_q[i].edge_trig;
            route_fiq[i] = cfg_q[i].route_fiq;
            prio_v[i]    = cfg_q[i].prio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            for (int i = 0; i < NSRC; i++) cfg_q[i] <= '0;
        end else if (wr_en) begin
            if (cfg_space) begin
                cfg_q[idx].prio      <= wdata[PRIO_W-1:0];
                cfg_q[idx].edge_trig <= wdata[CFG_EDGE_BIT];
                cfg_q[idx].route_fiq <= wdata[CFG_ROUTE_BIT];
            end else if (ctl_sel == CTL_MASK) begin
                mask_q <= wdata[NSRC-1:0];
            end
        end
    end

    assign ack_clr = (wr_en && !cfg_space && ctl_sel == CTL_PEND) ? wdata[NSRC-1:0] : '0;

    intc_capture #(.NSRC(NSRC)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .edge_mode_i (edge_mode),
        .ack_clr_i   (ack_clr),
        .pend_o      (pend)
    );

    assign elig_irq = pend & ~mask_q & ~route_fiq;
    assign elig_fiq = pend & ~mask_q & route_fiq;

    intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb_irq (
        .req_i   (elig_irq),
        .prio_i  (prio_v),
        .valid_o (irq_valid),
        .id_o    (irq_id)
    );

    intc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb_fiq (
        .req_i   (elig_fiq),
        .prio_i  (prio_v),
        .valid_o (fiq_valid),
        .id_o    (fiq_id)
    );

    assign irq_o = irq_valid;
    assign fiq_o = fiq_valid;

    always_comb begin
        rdata = '0;
        if (cfg_space) begin
            rdata[PRIO_W-1:0]    = cfg_q[idx].prio;
            rdata[CFG_EDGE_BIT]  = cfg_q[idx].edge_trig;
            rdata[CFG_ROUTE_BIT] = cfg_q[idx].route_fiq;
        end else begin
            unique case (ctl_sel)
                CTL_MASK:    rdata[NSRC-1:0] = mask_q;
                CTL_PEND:    rdata[NSRC-1:0] = pend;
                CTL_IRQ_WIN: begin
                    rdata[ID_W-1:0]   = irq_id;
                    rdata[DATA_W-1]   = irq_valid;
                end
                CTL_FIQ_WIN: begin
                    rdata[ID_W-1:0]   = fiq_id;
                    rdata[DATA_W-1]   = fiq_valid;
                end
                default:     rdata = '0;
            endcase
        end
    end

    // R5: a masked source never wins
    assert_irq_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !mask_q[irq_id]);
    assert_fiq_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_valid |-> !mask_q[fiq_id]);

    // R6: winners respect their route bit
    assert_irq_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !cfg_q[irq_id].route_fiq);
    assert_fiq_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_valid |-> cfg_q[fiq_id].route_fiq);

    // R8: a valid winner is a pending source
    assert_win_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid |-> pend[irq_id]) and (fiq_valid |-> pend[fiq_id]));

    // R7: no eligible source beats the winner
    for (genvar g = 0; g < NSRC; g++) begin : g_best
        assert_irq_best_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_valid && elig_irq[g]) |->
            ((prio_v[g] > prio_v[irq_id]) ||
             ((prio_v[g] == prio_v[irq_id]) && (ID_W'(g) >= irq_id))));
        assert_fiq_best_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (fiq_valid && elig_fiq[g]) |->
            ((prio_v[g] > prio_v[fiq_id]) ||
             ((prio_v[g] == prio_v[fiq_id]) && (ID_W'(g) >= fiq_id))));
    end
endmodule

// File: rtl/intc_bus_fsm.sv
module intc_bus_fsm
    import intc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] sel_rdata_i,
    output logic              accept_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);
    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:  if (req_i) state_d = BUS_REPLY;
            BUS_REPLY: state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BUS_IDLE && req_i && !we_i)
                rdata_q <= sel_rdata_i;
        end
    end

    always_comb begin
        accept_o = 1'b0;
        ack_o    = 1'b0;
        unique case (state_q)
            BUS_IDLE:  accept_o = req_i;
            BUS_REPLY: ack_o    = 1'b1;
            default:   ;
        endcase
        rdata_o = rdata_q;
    end

    // R10: acknowledge lasts one cycle and follows an acceptance
    assert_ack_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    assert_ack_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> ack_o);
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top #(
    parameter int NSRC   = 32,
    parameter int DATA_W = 32,
    localparam int ID_W   = $clog2(NSRC),
    localparam int ADDR_W = ID_W + 2,
    localparam int OFF_W  = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic [NSRC-1:0]   sec_src,
    input  logic [NSRC-3:0]   pri_src,
    output logic              irq_o,
    output logic              fiq_o
);
    logic              accept;
    logic              unit_sel;
    logic [OFF_W-1:0]  reg_addr;
    logic [DATA_W-1:0] pri_rdata, sec_rdata, sel_rdata;
    logic              sec_irq, sec_fiq;
    logic [NSRC-1:0]   pri_in;

    assign unit_sel = bus_addr[ADDR_W-1];
    assign reg_addr = bus_addr[OFF_W-1:0];
    assign sel_rdata = unit_sel ? sec_rdata : pri_rdata;
    assign pri_in   = {pri_src, sec_fiq, sec_irq};

    intc_bus_fsm #(.DATA_W(DATA_W)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (bus_req),
        .we_i        (bus_we),
        .sel_rdata_i (sel_rdata),
        .accept_o    (accept),
        .ack_o       (bus_ack),
        .rdata_o     (bus_rdata)
    );

    intc_unit #(.NSRC(NSRC), .DATA_W(DATA_W)) u_secondary (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (sec_src),
        .wr_en    (accept && bus_we && unit_sel),
        .reg_addr (reg_addr),
        .wdata    (bus_wdata),
        .rdata    (sec_rdata),
        .irq_o    (sec_irq),
        .fiq_o    (sec_fiq)
    );

    intc_unit #(.NSRC(NSRC), .DATA_W(DATA_W)) u_primary (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (pri_in),
        .wr_en    (accept && bus_we && !unit_sel),
        .reg_addr (reg_addr),
        .wdata    (bus_wdata),
        .rdata    (pri_rdata),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o)
    );

    // R1: outputs quiet right after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/irq_cascade_top_bench.sv
`timescale 1ns/1ps
module irq_cascade_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [31:0] sec_src = '0;
    logic [29:0] pri_src = '0;
    logic        irq_o, fiq_o;

    int checks = 0, fails = 0;
    logic [6:0]  cfg_m [2][32];   // {route, edge, prio}
    logic [31:0] mask_m [2];

    always #2.5 clk = ~clk;

    irq_cascade_top u_irq_cascade_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .sec_src(sec_src), .pri_src(pri_src),
        .irq_o(irq_o), .fiq_o(fiq_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input bit we, input int unit, input logic [5:0] off,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = {unit[0], off}; bus_wdata = wd;
        @(negedge clk);
        while (!bus_ack) @(negedge clk);
        rd = bus_rdata;
        bus_req = 1'b0;
        @(negedge clk);
        chk("R10 ack single cycle", {31'b0, bus_ack}, 32'h0);
    endtask

    task automatic wr(input int unit, input logic [5:0] off, input logic [31:0] wd);
        logic [31:0] dummy;
        bus_op(1'b1, unit, off, wd, dummy);
        if (off[5]) cfg_m[unit][off[4:0]] = {wd[9], wd[8], wd[4:0]};
        else if (off[1:0] == 2'd0) mask_m[unit] = wd;
    endtask

    task automatic rd(input int unit, input logic [5:0] off, output logic [31:0] d);
        bus_op(1'b0, unit, off, 32'h0, d);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected winner word: bit31 valid, bits 4:0 number
    function automatic logic [31:0] win(input int unit, input logic [31:0] pend, input bit fast);
        logic found = 1'b0;
        int best = 0;
        for (int i = 0; i < 32; i++) begin
            if (pend[i] && !mask_m[unit][i] && (cfg_m[unit][i][6] == fast)) begin
                if (!found || cfg_m[unit][i][4:0] < cfg_m[unit][best][4:0]) begin
                    found = 1'b1; best = i;
                end
            end
        end
        return found ? (32'h8000_0000 | 32'(best)) : 32'h0;
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, sw, sf, pp, exp_pi, exp_pf;
        for (int u = 0; u < 2; u++) begin
            mask_m[u] = '1;
            for (int s = 0; s < 32; s++) cfg_m[u][s] = '0;
        end
        void'($urandom(32'd1234));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 irq_o", {31'b0, irq_o}, 0);
        chk("R1 fiq_o", {31'b0, fiq_o}, 0);
        rd(0, 6'd0, d); chk("R1 primary mask", d, 32'hFFFF_FFFF);
        rd(1, 6'd0, d); chk("R1 secondary mask", d, 32'hFFFF_FFFF);
        rd(1, 6'd1, d); chk("R1 secondary pending", d, 0);
        rd(1, 6'h27, d); chk("R1 config word", d, 0);

        // R2 config fields
        wr(1, 6'h24, 32'hFFFF_FFFF);
        rd(1, 6'h24, d); chk("R2 config readback", d, 32'h0000_031F);
        wr(1, 6'h24, 32'h0);

        // cascade set-up: primary source 1 to fast path, only sources 0/1 unmasked
        wr(0, 6'h21, 32'h200);
        wr(0, 6'd0, 32'hFFFF_FFFC);
        wr(1, 6'd0, 32'h0);

        // R3 level capture, R9 cascade to primary source 0
        wr(1, 6'h25, 32'h3);
        @(negedge clk); sec_src[5] = 1'b1;
        wait_cyc(3);
        rd(1, 6'd1, d); chk("R3 level pending", d, 32'h20);
        chk("R9 irq_o via cascade", {31'b0, irq_o}, 1);
        rd(0, 6'd2, d); chk("R9 primary winner is source 0", d, 32'h8000_0000);
        rd(1, 6'd2, d); chk("R8 secondary irq winner", d, 32'h8000_0005);
        @(negedge clk); sec_src[5] = 1'b0;
        wait_cyc(3);
        rd(1, 6'd1, d); chk("R3 level release", d, 0);
        chk("R3 irq_o drops", {31'b0, irq_o}, 0);

        // R4 edge capture and acknowledge
        wr(1, 6'h29, 32'h101);
        @(negedge clk); sec_src[9] = 1'b1;
        @(negedge clk); sec_src[9] = 1'b0;
        wait_cyc(3);
        rd(1, 6'd1, d); chk("R4 edge held", d, 32'h200);
        rd(1, 6'd2, d); chk("R4 edge winner", d, 32'h8000_0009);
        wr(1, 6'd1, 32'h0);
        rd(1, 6'd1, d); chk("R4 zero write no effect", d, 32'h200);
        wr(1, 6'd1, 32'h200);
        rd(1, 6'd1, d); chk("R4 acknowledge clears", d, 0);
        chk("R4 irq_o after ack", {31'b0, irq_o}, 0);

        // R5 masking
        @(negedge clk); sec_src[5] = 1'b1;
        wr(1, 6'd0, 32'h20);
        wait_cyc(3);
        rd(1, 6'd1, d); chk("R5 masked still pending", d, 32'h20);
        rd(1, 6'd2, d); chk("R5 masked not winner", d, 0);
        chk("R5 irq_o blocked", {31'b0, irq_o}, 0);
        wr(1, 6'd0, 32'h0);
        wait_cyc(3);
        chk("R5 unmask restores", {31'b0, irq_o}, 1);

        // R6 routing to fast path
        wr(1, 6'h25, 32'h203);
        wait_cyc(3);
        chk("R6 fiq_o", {31'b0, fiq_o}, 1);
        chk("R6 irq_o", {31'b0, irq_o}, 0);
        rd(1, 6'd3, d); chk("R6 fast winner", d, 32'h8000_0005);
        rd(1, 6'd2, d); chk("R6 normal winner empty", d, 0);

        // R7 priority and tie
        wr(1, 6'h25, 32'h3);
        wr(1, 6'h2C, 32'h3);
        @(negedge clk); sec_src[12] = 1'b1;
        wait_cyc(3);
        rd(1, 6'd2, d); chk("R7 tie lowest number", d, 32'h8000_0005);
        wr(1, 6'h34, 32'h1);
        @(negedge clk); sec_src[20] = 1'b1;
        wait_cyc(3);
        rd(1, 6'd2, d); chk("R7 lower value wins", d, 32'h8000_0014);

        // R10 winner registers are read-only
        wr(1, 6'd2, 32'h0000_0003);
        rd(1, 6'd2, d); chk("R10 winner write ignored", d, 32'h8000_0014);

        // clean-up before random phase
        @(negedge clk); sec_src = '0; pri_src = '0;
        wait_cyc(2);
        wr(0, 6'd1, 32'hFFFF_FFFF);
        wr(1, 6'd1, 32'hFFFF_FFFF);

        // random phase: level sources, priorities 0..3, random routes and masks
        for (int it = 0; it < 25; it++) begin
            for (int u = 0; u < 2; u++)
                for (int s = 0; s < 32; s++)
                    wr(u, {1'b1, 5'(s)}, $urandom & 32'hFFFF_FEE3);
            wr(0, 6'd0, $urandom);
            wr(1, 6'd0, $urandom);
            @(negedge clk);
            sec_src = $urandom;
            pri_src = 30'($urandom);
            wait_cyc(3);
            sw = win(1, sec_src, 1'b0);
            sf = win(1, sec_src, 1'b1);
            pp = {pri_src, sf[31], sw[31]};
            exp_pi = win(0, pp, 1'b0);
            exp_pf = win(0, pp, 1'b1);
            chk("R8 irq_o random", {31'b0, irq_o}, {31'b0, exp_pi[31]});
            chk("R8 fiq_o random", {31'b0, fiq_o}, {31'b0, exp_pf[31]});
            rd(1, 6'd2, d); chk("R7 secondary normal winner", d, sw);
            rd(1, 6'd3, d); chk("R6 secondary fast winner", d, sf);
            rd(0, 6'd2, d); chk("R9 primary normal winner", d, exp_pi);
            rd(0, 6'd3, d); chk("R9 primary fast winner", d, exp_pf);
            rd(1, 6'd1, d); chk("R3 secondary pending random", d, sec_src);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule